// File: doc/BRIEF.md
# Bit-Serial All-One-Polynomial Field Multiplier

This block multiplies two elements of GF(2^M) when the field is built on the all-one polynomial x^M + x^(M-1) + ... + x + 1. Each operand is given as M+1 coefficients over the redundant basis {1, α, ..., α^M}. In that basis α^(M+1) = 1, so the product is a cyclic convolution of length M+1. The datapath therefore needs no reduction taps. One operand register rotates and the other stays still.

A caller presents both operands as parallel words and pulses `start` while the block is idle. From the next cycle the block emits one product coefficient per cycle on `coef_out`, highest index first. The result takes M+1 cycles. `coef_valid` marks each emitted coefficient and `coef_last` marks the final one.

The fixed operand can be replaced by a constant chosen at elaboration time. This turns the block into a constant multiplier with no register for that operand. Converting results to or from the plain M-coefficient polynomial basis is left to the surrounding logic.

Top module: `gf_aop_serial_mul`

## Requirements
- R1: Elaboration accepts M only when M+1 is prime and 2 has multiplicative order exactly M modulo M+1. Examples: M=4 and M=10 are accepted; M=3 and M=6 are rejected. The package function `aop_field_ok` gives this verdict.
- R2: A `start` that is high at a clock edge while `busy` is low captures bit i of `op_b` and bit i of `op_c` as coefficients b_i and c_i, for i = 0..M. In the following cycle `busy` and `coef_valid` are high.
- R3: Define a_k = XOR over i of (b_i AND c_((k-i) mod (M+1))). In the cycles after a capture, `coef_out` presents a_M, a_(M-1), ..., a_0, one coefficient per cycle, over M+1 consecutive valid cycles.
- R4: `coef_last` is high in exactly one cycle per product, the cycle that presents a_0. `busy` is low in the cycle after it.
- R5: A `start` that arrives while `busy` is high is ignored. This includes a `start` in the `coef_last` cycle. Such a `start` does not alter the product in flight and does not begin a new product.
- R6: While `busy` is low, `coef_valid`, `coef_last` and `coef_out` are all 0. After a synchronous reset (`rst_n` low at a clock edge), `busy` is low.
- R7: With parameter `HARD_C` = 1, parameter `CONST_C` supplies the coefficients c_i (bit i gives c_i) and `op_c` has no effect on the product.
- R8: A reset that arrives partway through a product abandons it. `busy` is low in the next cycle, and a later `start` yields a correct new product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to load operands; honoured only when idle |
| op_b | input | M+1 | Rotating operand, bit i = coefficient of α^i |
| op_c | input | M+1 | Fixed operand, bit i = coefficient of α^i (unused if HARD_C=1) |
| busy | output | 1 | A product is being emitted |
| coef_out | output | 1 | Current product coefficient |
| coef_valid | output | 1 | `coef_out` carries a product coefficient |
| coef_last | output | 1 | `coef_out` carries a_0, the final coefficient |

## Verification
The case that needs the most care is a new `start` request arriving in the same cycle that the last coefficient is emitted. At that point the control must finish the current product and refuse the new load, which leaves one idle cycle before the next product. The bench provokes this by raising `start` at random on about half of all cycles, with fresh operand data each cycle. A behavioural model that computes the cyclic convolution, with its own idle/busy sequencing, is compared with the outputs on every clock. If the block loaded early or lost the gap cycle, the model would flag a wrong coefficient, a wrong `coef_last` or a wrong `busy`.

// File: rtl/gf_aop_pkg.sv
// Package: shared helpers for the all-one-polynomial serial multiplier.
// Assumes: field size m is a small elaboration-time integer.
package gf_aop_pkg;

    // Checks that m+1 is prime and that 2 has order m modulo m+1 (R1).
    function automatic bit aop_field_ok(input int m);
        int n;
        int p;
        n = m + 1;
        if (m < 2) return 1'b0;
        for (int d = 2; d * d <= n; d++) begin
            if (n % d == 0) return 1'b0;
        end
        p = 1;
        for (int e = 1; e <= m; e++) begin
            p = (p * 2) % n;
            if (p == 1 && e < m) return 1'b0;
        end
        return (p == 1);
    endfunction

endpackage

// File: rtl/aop_rot_reg.sv
// Module: rotating operand register.
// Loads N bits in parallel; on shift, every bit moves one place toward the
// MSB and the MSB wraps into bit 0 (multiplication by α when α^N = 1).
// Assumes: load and shift are never high together.
module aop_rot_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Holds the rotating operand, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= d;
        else if (shift) q <= {q[N-2:0], q[N-1]};
    end
endmodule

// File: rtl/aop_coef_reg.sv
// Module: fixed operand holder.
// Either a plain load register or, when HARD is set, a hardwired constant.
// Assumes: the operand never moves after loading.
module aop_coef_reg #(
    parameter int         N    = 5,
    parameter bit         HARD = 1'b0,
    parameter logic [N-1:0] KC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    if (HARD) begin : g_const
        logic unused_inputs;
        // Ties off the inputs that the constant variant does not need.
        assign unused_inputs = ^{clk, rst_n, load, d};
        assign q = KC;
    end else begin : g_reg
        logic [N-1:0] q_r;
        // Captures the fixed operand on load, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)    q_r <= '0;
            else if (load) q_r <= d;
        end
        assign q = q_r;
    end
endmodule

// File: rtl/aop_and_xor.sv
// Module: one row of AND gates feeding an XOR tree.
// Pairs x_i with y_(N-1-i); with x rotating, this yields successive
// coefficients of the length-N cyclic convolution.
// Assumes: purely combinational, N >= 2.
module aop_and_xor #(
    parameter int N = 5
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic         bit_out
);
    logic [N-1:0] terms;

    for (genvar i = 0; i < N; i++) begin : g_and
        // Forms one partial product term.
        assign terms[i] = x[i] & y[N-1-i];
    end

    // Sums the partial products over GF(2).
    assign bit_out = ^terms;
endmodule

// File: rtl/aop_seq.sv
// Module: sequencer for one product.
// Accepts start only when idle, then runs for M+1 cycles, counting the
// coefficient index down from M to 0.
// Assumes: M >= 2.
module aop_seq #(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic shift,
    output logic last
);
    localparam int CW = $clog2(M + 1);

    logic [CW-1:0] idx_q;

    // Tracks the busy state and the index of the coefficient now on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                idx_q <= CW'(M);
            end
        end else if (idx_q == '0) begin
            busy <= 1'b0;
        end else begin
            idx_q <= idx_q - 1'b1;
        end
    end

    // Derives the datapath strobes from the state.
    always_comb begin
        load  = start & ~busy;
        last  = busy & (idx_q == '0);
        shift = busy & (idx_q != '0);
    end
endmodule

// File: rtl/gf_aop_serial_mul.sv
// Module: bit-serial GF(2^M) multiplier over the extended basis
// {1, α, ..., α^M} of the all-one polynomial field.
// Emits product coefficients a_M down to a_0, one per cycle, after start.
// Assumes: M passes the field check; HARD_C selects a constant c operand.
module gf_aop_serial_mul #(
    parameter int       M       = 4,
    parameter bit       HARD_C  = 1'b0,
    parameter logic [M:0] CONST_C = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [M:0] op_b,
    input  logic [M:0] op_c,
    output logic       busy,
    output logic       coef_out,
    output logic       coef_valid,
    output logic       coef_last
);
    localparam int N = M + 1;

    if (!gf_aop_pkg::aop_field_ok(M)) begin : g_bad_field
        $error("gf_aop_serial_mul: M gives no all-one-polynomial field");
    end

    logic         load;
    logic         shift;
    logic         raw_bit;
    logic [N-1:0] x_q;
    logic [N-1:0] y_q;

    aop_seq #(.M(M)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .shift (shift),
        .last  (coef_last)
    );

    aop_rot_reg #(.N(N)) u_xreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .d     (op_b),
        .q     (x_q)
    );

    aop_coef_reg #(.N(N), .HARD(HARD_C), .KC(CONST_C)) u_yreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (op_c),
        .q     (y_q)
    );

    aop_and_xor #(.N(N)) u_tree (
        .x       (x_q),
        .y       (y_q),
        .bit_out (raw_bit)
    );

    // Qualifies the serial output so it reads 0 while idle.
    always_comb begin
        coef_out   = raw_bit & busy;
        coef_valid = busy;
    end
endmodule

// File: rtl/gf_aop_serial_mul_chk.sv
// Module: property checker for gf_aop_serial_mul, attached by bind.
// Assumes: it observes the top's ports and its rotating register x_q.
module gf_aop_serial_mul_chk #(
    parameter int M = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       coef_out,
    input logic       coef_valid,
    input logic       coef_last,
    input logic [M:0] x_q
);
    localparam int CW = $clog2(M + 2);

    logic [CW-1:0] run_q;

    // Counts the busy cycles elapsed in the current product.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!coef_valid && !coef_last && !coef_out));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && coef_valid));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !coef_last) |=> busy);

    assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !coef_last) |=> (x_q == {$past(x_q[M-1:0]), $past(x_q[M])}));

    assert_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_last |-> (run_q == CW'(M)));

    assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        coef_last |=> !busy);
endmodule

bind gf_aop_serial_mul gf_aop_serial_mul_chk #(.M(M)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .coef_out   (coef_out),
    .coef_valid (coef_valid),
    .coef_last  (coef_last),
    .x_q        (x_q)
);

// File: tb/gf_aop_serial_mul_test.sv
// One test lane: a multiplier instance, its stimulus and a behavioural
// model compared on every clock.
module aop_lane #(
    parameter int       M     = 4,
    parameter bit       HARD  = 1'b0,
    parameter logic [M:0] KC  = '0,
    parameter bit       EXH   = 1'b0,
    parameter int       NRAND = 200
) (
    input  logic clk,
    output logic fin
);
    localparam int N = M + 1;

    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [M:0] op_b  = '0;
    logic [M:0] op_c  = '0;
    logic       busy, coef_out, coef_valid, coef_last;

    int n_chk = 0;
    int n_bad = 0;

    gf_aop_serial_mul #(.M(M), .HARD_C(HARD), .CONST_C(KC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_b(op_b), .op_c(op_c),
        .busy(busy), .coef_out(coef_out), .coef_valid(coef_valid),
        .coef_last(coef_last)
    );

    // Behavioural model state.
    bit m_busy = 1'b0;
    int m_idx  = 0;
    bit m_b[N];
    bit m_c[N];
    bit seen_edge = 1'b0;

    function automatic bit conv(int k);
        bit s = 1'b0;
        for (int i = 0; i < N; i++) s ^= m_b[i] & m_c[((k - i) % N + N) % N];
        return s;
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        seen_edge = 1'b1;
        if (!rst_n) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            if (m_idx == 0) m_busy = 1'b0;
            else m_idx = m_idx - 1;
        end else if (start) begin
            m_busy = 1'b1;
            m_idx  = M;
            for (int i = 0; i < N; i++) begin
                m_b[i] = op_b[i];
                m_c[i] = HARD ? KC[i] : op_c[i];
            end
        end
    end

    task automatic chk(input bit got, input bit exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s M=%0d t=%0t got=%0b exp=%0b", req, M, $time, got, exp);
        end
    endtask

    // Compares every output with the model away from the active edge.
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(busy, m_busy, "R5 busy");
            chk(coef_valid, m_busy, "R2 valid");
            chk(coef_last, m_busy && m_idx == 0, "R4 last");
            chk(coef_out, m_busy ? conv(m_idx) : 1'b0, HARD ? "R7 coef" : "R3 coef");
        end
    end

    task automatic issue(input logic [M:0] b, input logic [M:0] c);
        while (busy) @(negedge clk);
        start = 1'b1; op_b = b; op_c = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        logic [31:0] r1, r2;
        fin = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy, 1'b0, "R6 reset busy");
        chk(coef_valid, 1'b0, "R6 reset valid");
        rst_n = 1'b1;
        @(negedge clk);
        if (EXH) begin
            for (int bb = 0; bb < (1 << N); bb++) begin
                for (int cc = 0; cc < (1 << N); cc++) begin
                    r1 = bb; r2 = cc;
                    issue(r1[M:0], r2[M:0]);
                end
            end
        end
        for (int k = 0; k < NRAND; k++) begin
            r1 = $urandom; r2 = $urandom;
            issue(r1[M:0], r2[M:0]);
        end
        // R5: dense starts with fresh data each cycle, hitting the last cycle.
        for (int k = 0; k < NRAND * N; k++) begin
            r1 = $urandom; r2 = $urandom;
            start = r1[31]; op_b = r1[M:0]; op_c = r2[M:0];
            @(negedge clk);
        end
        start = 1'b0;
        // R8: abandon a product partway through.
        @(negedge clk);
        r1 = $urandom; r2 = $urandom;
        issue(r1[M:0], r2[M:0]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy, 1'b0, "R8 abort");
        r1 = $urandom; r2 = $urandom;
        issue(r1[M:0], r2[M:0]);
        repeat (N + 2) @(negedge clk);
        fin = 1'b1;
    end
endmodule

// Top bench: runs three lanes and the field-legality checks.
module gf_aop_serial_mul_test;
    logic clk = 1'b0;
    logic f4, f10, fk;
    int   pkg_chk = 0;
    int   pkg_bad = 0;
    int   cycles  = 0;
    bit   timeout = 1'b0;

    always #2.5 clk = ~clk;

    aop_lane #(.M(4),  .EXH(1'b1), .NRAND(200)) l4  (.clk(clk), .fin(f4));
    aop_lane #(.M(10), .NRAND(300))             l10 (.clk(clk), .fin(f10));
    aop_lane #(.M(4),  .HARD(1'b1), .KC(5'b10110), .EXH(1'b1), .NRAND(100))
        lk (.clk(clk), .fin(fk));

    task automatic chk_field(input int m, input bit exp);
        bit got;
        got = gf_aop_pkg::aop_field_ok(m);
        pkg_chk++;
        if (got !== exp) begin
            pkg_bad++;
            $display("FAIL R1 field m=%0d got=%0b exp=%0b", m, got, exp);
        end
    endtask

    initial begin
        chk_field(4, 1'b1);
        chk_field(10, 1'b1);
        chk_field(2, 1'b1);
        chk_field(3, 1'b0);
        chk_field(6, 1'b0);
        chk_field(1, 1'b0);
        while (!(f4 && f10 && fk) && cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        if (!(f4 && f10 && fk)) begin
            timeout = 1'b1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
        end
        $display("[TB] %0d tests run, %0d failed",
                 pkg_chk + l4.n_chk + l10.n_chk + lk.n_chk + (timeout ? 1 : 0),
                 pkg_bad + l4.n_bad + l10.n_bad + lk.n_bad + (timeout ? 1 : 0));
        $finish;
    end
endmodule